// File: doc/BRIEF.md
# Coprocessor Run Control and Status

This block owns the run/stop state and the 16-bit status flag register of a small coprocessor. A host sets the run bit to start the program. The instruction pipeline reports a decoded halt opcode together with the opcode's address. The block then clears the run bit, raises the interrupt flag and hands the pipeline a program counter value two bytes past the halt opcode. The opcode byte that follows the halt is prefetched but never executed.

A halt must not complete while the external write buffer still holds a store. While a store is pending, the block waits in a drain state and does not hold the drain back. The block also tracks whether the instruction cache is enabled. Two mode bits are kept here and brought out as mode outputs: one from the config byte and one from the clock-select byte.

Host writes to the config byte, the clock-select byte and the status register's low byte share one 8-bit data bus. Each write has its own strobe.

Top module: `copro_run_ctrl`

## Requirements
- R1: After reset, `go`, `sfr`, `irqOut`, `cacheEn`, `cacheInval`, `pcLoad`, `fastMul` and `fastClk` are all 0.
- R2: A status write (`hostSfrWr`) with `hostData` bit 5 = 1 sets `go` (which is `sfr` bit 5) on the next cycle. `go` then stays 1 until a halt completes or a status write with bit 5 = 0 arrives.
- R3: Suppose `stopEvt` is pulsed at address A while `go` = 1 and no store is pending. On the next cycle `go` = 0, the interrupt flag (`sfr` bit 15) = 1, `pcLoad` is 1 for exactly one cycle, and `pcValue` = A + 2, modulo 2^16.
- R4: A completed halt sets the interrupt flag whatever the config mask bit (config bit 7) holds. `irqOut` equals the flag AND NOT the mask.
- R5: A halt taken while `storePending` = 1 keeps `go` = 1 and `pcLoad` = 0. It completes on the cycle after the first cycle in which `storePending` = 0.
- R6: Status bits 1 to 5 are written from `hostData` bits 1 to 5. Status bit 0 and bits 6 to 14 always read 0. A status write cannot set bit 15.
- R7: A `hostSfrRd` pulse clears the interrupt flag on the next cycle. If a halt completes in that same cycle, the flag is set instead.
- R8: A `cacheOp` pulse sets `cacheEn`. A status write with bit 5 = 0 clears `cacheEn` and pulses `cacheInval` for one cycle. If both arrive in the same cycle, the clear wins.
- R9: `fastMul` follows config bit 5 and `fastClk` follows clock-select bit 0. Each updates on the cycle after its own write, and both may be 1 together.
- R10: If a halt completes in the same cycle as a status write with bit 5 = 1, `go` ends at 0 and the halt completes normally.
- R11: `stopEvt` while `go` = 0 is ignored: no `pcLoad`, and the interrupt flag and `go` are unchanged.
- R12: A status write with bit 5 = 0 during the drain wait cancels the halt. No interrupt flag and no `pcLoad` follow, even after the store drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopEvt | input | 1 | Decoded halt opcode, one-cycle pulse |
| stopPc | input | PC_W | Address of the halt opcode |
| storePending | input | 1 | Write buffer still holds a store |
| cacheOp | input | 1 | Cache-load opcode executed, one-cycle pulse |
| hostSfrWr | input | 1 | Host write to the status low byte |
| hostCfgWr | input | 1 | Host write to the config byte |
| hostClkWr | input | 1 | Host write to the clock-select byte |
| hostSfrRd | input | 1 | Host read of the status register |
| hostData | input | 8 | Host write data |
| go | output | 1 | Run state |
| sfr | output | 16 | Status register read value |
| irqOut | output | 1 | Interrupt request to the host |
| cacheEn | output | 1 | Instruction cache enabled |
| cacheInval | output | 1 | One-cycle cache invalidate pulse |
| pcLoad | output | 1 | Load `pcValue` into the program counter |
| pcValue | output | PC_W | Program counter after the halt |
| fastMul | output | 1 | Fast multiply mode |
| fastClk | output | 1 | Fast core clock mode |

## Verification
Three functions can land on the same clock edge. A halt can complete in the cycle the host reads the status register, in the cycle the host writes the run bit, or in the cycle a cache-load opcode meets a host clear. Each pair is provoked by driving both pulses in one cycle. The result is judged by the flag, run bit and cache state one cycle later, against the priorities stated in R7, R8 and R10. A host clear that arrives during a drain wait is checked the same way: no interrupt and no program counter load may follow once the store drains.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int SFR_W        = 16;
  localparam int HOST_W       = 8;
  localparam int SFR_GO_BIT   = 5;
  localparam int SFR_IRQ_BIT  = 15;
  localparam int CFG_MASK_BIT = 7;
  localparam int CFG_FMUL_BIT = 5;
  localparam int CLK_FAST_BIT = 0;
  localparam int STOP_SKIP    = 2;

  typedef struct packed {
    logic stopTake;
    logic stopDone;
    logic goSet;
    logic goClr;
    logic irqClr;
    logic cacheOn;
    logic cacheOff;
  } runStrb_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_DRAIN = 1'b1} runState_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stopEvt,
  input  logic     storePending,
  input  logic     hostSfrWr,
  input  logic     hostGoBit,
  input  logic     hostSfrRd,
  input  logic     cacheOp,
  input  logic     go,
  output runStrb_t strb
);
  runState_t state, stateNxt;
  logic hostClr;
  logic take;
  logic done;

  always_comb begin
    hostClr = hostSfrWr && !hostGoBit;
    take    = stopEvt && go && (state == ST_IDLE);
    done    = (take && !storePending) || ((state == ST_DRAIN) && !storePending);

    strb.stopTake = take;
    strb.stopDone = done;
    strb.goSet    = hostSfrWr && hostGoBit && !done;
    strb.goClr    = done || hostClr;
    strb.irqClr   = hostSfrRd && !done;
    strb.cacheOff = hostClr;
    strb.cacheOn  = cacheOp && !hostClr;

    stateNxt = state;
    case (state)
      ST_IDLE:  if (take && storePending && !hostClr) stateNxt = ST_DRAIN;
      ST_DRAIN: if (!storePending || hostClr) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R5
  drain_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> go);
endmodule

// File: rtl/rcs_dpath.sv
module rcs_dpath
  import rcs_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  runStrb_t          strb,
  input  logic [PC_W-1:0]   stopPc,
  input  logic              hostSfrWr,
  input  logic              hostCfgWr,
  input  logic              hostClkWr,
  input  logic [HOST_W-1:0] hostData,
  output logic              go,
  output logic [SFR_W-1:0]  sfr,
  output logic              irqOut,
  output logic              cacheEn,
  output logic              cacheInval,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcValue,
  output logic              fastMul,
  output logic              fastClk
);
  localparam int FLAG_W = SFR_GO_BIT - 1;

  logic              irqFlag;
  logic [FLAG_W-1:0] flags;
  logic              cfgMask;
  logic [PC_W-1:0]   pcHold;
  logic [PC_W-1:0]   pcBase;

  assign pcBase = strb.stopTake ? stopPc : pcHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      go         <= 1'b0;
      irqFlag    <= 1'b0;
      flags      <= '0;
      cacheEn    <= 1'b0;
      cacheInval <= 1'b0;
      pcLoad     <= 1'b0;
      pcValue    <= '0;
      pcHold     <= '0;
      cfgMask    <= 1'b0;
      fastMul    <= 1'b0;
      fastClk    <= 1'b0;
    end else begin
      if (strb.goClr)      go <= 1'b0;
      else if (strb.goSet) go <= 1'b1;

      if (strb.stopDone)    irqFlag <= 1'b1;
      else if (strb.irqClr) irqFlag <= 1'b0;

      if (hostSfrWr) flags <= hostData[SFR_GO_BIT-1:1];

      if (strb.cacheOff)     cacheEn <= 1'b0;
      else if (strb.cacheOn) cacheEn <= 1'b1;
      cacheInval <= strb.cacheOff;

      if (strb.stopTake) pcHold <= stopPc;
      pcLoad <= strb.stopDone;
      if (strb.stopDone) pcValue <= pcBase + PC_W'(STOP_SKIP);

      if (hostCfgWr) begin
        cfgMask <= hostData[CFG_MASK_BIT];
        fastMul <= hostData[CFG_FMUL_BIT];
      end
      if (hostClkWr) fastClk <= hostData[CLK_FAST_BIT];
    end
  end

  always_comb begin
    sfr                  = '0;
    sfr[SFR_IRQ_BIT]     = irqFlag;
    sfr[SFR_GO_BIT]      = go;
    sfr[SFR_GO_BIT-1:1]  = flags;
  end

  assign irqOut = irqFlag && !cfgMask;

  // R3
  stop_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (!go && irqFlag));

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> pcLoad);

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(strb.irqClr));

  // R8
  cache_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    cacheInval |-> !cacheEn);
endmodule

// File: rtl/copro_run_ctrl.sv
module copro_run_ctrl
  import rcs_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopEvt,
  input  logic [PC_W-1:0]   stopPc,
  input  logic              storePending,
  input  logic              cacheOp,
  input  logic              hostSfrWr,
  input  logic              hostCfgWr,
  input  logic              hostClkWr,
  input  logic              hostSfrRd,
  input  logic [HOST_W-1:0] hostData,
  output logic              go,
  output logic [SFR_W-1:0]  sfr,
  output logic              irqOut,
  output logic              cacheEn,
  output logic              cacheInval,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcValue,
  output logic              fastMul,
  output logic              fastClk
);
  runStrb_t strb;
  logic     unusedBit;

  assign unusedBit = hostData[6];

  rcs_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .stopEvt      (stopEvt),
    .storePending (storePending),
    .hostSfrWr    (hostSfrWr),
    .hostGoBit    (hostData[SFR_GO_BIT]),
    .hostSfrRd    (hostSfrRd),
    .cacheOp      (cacheOp),
    .go           (go),
    .strb         (strb)
  );

  rcs_dpath #(.PC_W(PC_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .stopPc     (stopPc),
    .hostSfrWr  (hostSfrWr),
    .hostCfgWr  (hostCfgWr),
    .hostClkWr  (hostClkWr),
    .hostData   (hostData),
    .go         (go),
    .sfr        (sfr),
    .irqOut     (irqOut),
    .cacheEn    (cacheEn),
    .cacheInval (cacheInval),
    .pcLoad     (pcLoad),
    .pcValue    (pcValue),
    .fastMul    (fastMul),
    .fastClk    (fastClk)
  );
endmodule

// File: tb/copro_run_ctrl_tb.sv
module copro_run_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stopEvt = 1'b0;
  logic [15:0] stopPc = '0;
  logic        storePending = 1'b0;
  logic        cacheOp = 1'b0;
  logic        hostSfrWr = 1'b0;
  logic        hostCfgWr = 1'b0;
  logic        hostClkWr = 1'b0;
  logic        hostSfrRd = 1'b0;
  logic [7:0]  hostData = '0;
  logic        go;
  logic [15:0] sfr;
  logic        irqOut, cacheEn, cacheInval, pcLoad, fastMul, fastClk;
  logic [15:0] pcValue;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  copro_run_ctrl u_dut (
    .clk(clk), .rstN(rstN), .stopEvt(stopEvt), .stopPc(stopPc),
    .storePending(storePending), .cacheOp(cacheOp), .hostSfrWr(hostSfrWr),
    .hostCfgWr(hostCfgWr), .hostClkWr(hostClkWr), .hostSfrRd(hostSfrRd),
    .hostData(hostData), .go(go), .sfr(sfr), .irqOut(irqOut),
    .cacheEn(cacheEn), .cacheInval(cacheInval), .pcLoad(pcLoad),
    .pcValue(pcValue), .fastMul(fastMul), .fastClk(fastClk)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic sfrWr(input logic [7:0] d);
    hostSfrWr = 1'b1; hostData = d; cyc(); hostSfrWr = 1'b0;
  endtask

  task automatic cfgWr(input logic [7:0] d);
    hostCfgWr = 1'b1; hostData = d; cyc(); hostCfgWr = 1'b0;
  endtask

  task automatic clkWr(input logic [7:0] d);
    hostClkWr = 1'b1; hostData = d; cyc(); hostClkWr = 1'b0;
  endtask

  task automatic stopAt(input logic [15:0] a);
    stopEvt = 1'b1; stopPc = a; cyc(); stopEvt = 1'b0;
  endtask

  task automatic rdSfr();
    hostSfrRd = 1'b1; cyc(); hostSfrRd = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 go", {15'd0, go}, 16'd0);
    chk("R1 sfr", sfr, 16'h0000);
    chk("R1 outs", {8'd0, irqOut, cacheEn, cacheInval, pcLoad, fastMul, fastClk, 2'b0}, 16'd0);
  endtask

  task automatic testGo();
    sfrWr(8'h20);
    chk("R2 go set", sfr, 16'h0020);
    repeat (3) cyc();
    chk("R2 go held", {15'd0, go}, 16'd1);
  endtask

  task automatic testStop();
    stopAt(16'h1234);
    chk("R3 sfr after stop", sfr, 16'h8000);
    chk("R3 pcLoad", {15'd0, pcLoad}, 16'd1);
    chk("R3 pcValue", pcValue, 16'h1236);
    chk("R4 irqOut unmasked", {15'd0, irqOut}, 16'd1);
    cyc();
    chk("R3 pcLoad one cycle", {15'd0, pcLoad}, 16'd0);
    rdSfr();
    chk("R7 read clears", sfr, 16'h0000);
  endtask

  task automatic testMask();
    cfgWr(8'h80);
    sfrWr(8'h20);
    stopAt(16'hFFFF);
    chk("R4 flag set while masked", sfr, 16'h8000);
    chk("R4 irqOut masked", {15'd0, irqOut}, 16'd0);
    chk("R3 pcValue wraps", pcValue, 16'h0001);
    cfgWr(8'h00);
    chk("R4 irqOut unmask", {15'd0, irqOut}, 16'd1);
    rdSfr();
  endtask

  task automatic testDrain();
    sfrWr(8'h20);
    storePending = 1'b1;
    stopAt(16'h00FE);
    chk("R5 go while draining", {15'd0, go}, 16'd1);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 no pcLoad while draining", {15'd0, pcLoad}, 16'd0);
    end
    storePending = 1'b0;
    cyc();
    chk("R5 completes after drain", {14'd0, go, pcLoad}, 16'd1);
    chk("R5 pcValue", pcValue, 16'h0100);
    rdSfr();
  endtask

  task automatic testFlags();
    sfrWr(8'hFF);
    chk("R6 writable bits", sfr, 16'h003E);
    sfrWr(8'h2A);
    chk("R6 pattern", sfr, 16'h002A);
    sfrWr(8'h00);
    chk("R6 clear", sfr, 16'h0000);
  endtask

  task automatic testCache();
    cacheOp = 1'b1; cyc(); cacheOp = 1'b0;
    chk("R8 cache on", {15'd0, cacheEn}, 16'd1);
    sfrWr(8'h20);
    chk("R8 go set keeps cache", {15'd0, cacheEn}, 16'd1);
    sfrWr(8'h00);
    chk("R8 host clear", {14'd0, cacheEn, cacheInval}, 16'd1);
    cyc();
    chk("R8 inval pulse ends", {15'd0, cacheInval}, 16'd0);
    cacheOp = 1'b1; hostSfrWr = 1'b1; hostData = 8'h00; cyc();
    cacheOp = 1'b0; hostSfrWr = 1'b0;
    chk("R8 clear wins", {14'd0, cacheEn, cacheInval}, 16'd1);
  endtask

  task automatic testModes();
    cfgWr(8'h20);
    chk("R9 fast mul only", {14'd0, fastMul, fastClk}, 16'd2);
    clkWr(8'h01);
    chk("R9 both fast", {14'd0, fastMul, fastClk}, 16'd3);
    cfgWr(8'h00);
    chk("R9 fast clk only", {14'd0, fastMul, fastClk}, 16'd1);
    clkWr(8'h00);
    chk("R9 both slow", {14'd0, fastMul, fastClk}, 16'd0);
  endtask

  task automatic testReadCollide();
    sfrWr(8'h20);
    stopEvt = 1'b1; stopPc = 16'h4000; hostSfrRd = 1'b1; cyc();
    stopEvt = 1'b0; hostSfrRd = 1'b0;
    chk("R7 set wins over read", sfr, 16'h8000);
    rdSfr();
  endtask

  task automatic testGoCollide();
    sfrWr(8'h20);
    stopEvt = 1'b1; stopPc = 16'h0010; hostSfrWr = 1'b1; hostData = 8'h20; cyc();
    stopEvt = 1'b0; hostSfrWr = 1'b0;
    chk("R10 go ends low", {15'd0, go}, 16'd0);
    chk("R10 halt completes", pcValue, 16'h0012);
    rdSfr();
  endtask

  task automatic testIgnored();
    stopAt(16'h5555);
    chk("R11 no pcLoad", {15'd0, pcLoad}, 16'd0);
    chk("R11 sfr unchanged", sfr, 16'h0000);
  endtask

  task automatic testCancel();
    sfrWr(8'h20);
    storePending = 1'b1;
    stopAt(16'h0200);
    sfrWr(8'h00);
    chk("R12 go cleared", {15'd0, go}, 16'd0);
    storePending = 1'b0;
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk("R12 no completion", {14'd0, pcLoad, sfr[15]}, 16'd0);
    end
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    testReset();
    testGo();
    testStop();
    testMask();
    testDrain();
    testFlags();
    testCache();
    testModes();
    testReadCollide();
    testGoCollide();
    testIgnored();
    testCancel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule